// File: doc/BRIEF.md
# General Purpose Event Register Bank

A byte-addressed bank of event registers whose total byte count is a parameter. The lower half of the address space holds status bytes and the upper half holds the enable byte that pairs with each status byte. Event lines from hardware set bits in status byte 0. Software clears status bits by writing ones to them and programs enables by plain writes.

The `pending` output drives the system control interrupt. It is high while any bit of status byte 0 is also enabled in enable byte 0. Status and enable bytes above index 0 can be stored and read back, but they never raise the interrupt.

An access at or beyond the bank length reads as zero, changes nothing and pulses `err`. Reads are registered: `rdata` shows the addressed byte on the cycle after a read strobe and then holds until the next read.

Top module: `gpe_bank`

## Requirements
- R1: With `BANK_LEN`=8, addresses 0..3 select status bytes 0..3, and a read returns the status byte with the same index.
- R2: Addresses 4..7 select enable byte (address − 4), and a read returns that enable byte.
- R3: Writing a status byte clears every bit written as 1 and leaves the other bits of that byte unchanged.
- R4: Writing an enable byte replaces its whole contents with the written data.
- R5: On each clock, every bit that is high on `evt_in` is ORed into status byte 0, and it stays set until it is cleared by a write.
- R6: When an event bit and a write-one-to-clear hit the same bit of status byte 0 in the same cycle, the bit ends up set.
- R7: `pending` is high exactly when status byte 0 AND enable byte 0 is nonzero. The registers take their new values on a clock edge, and `pending` follows them on that same edge. Status and enable bytes other than byte 0 have no effect on `pending`.
- R8: While `rst_n` is low, every status byte, every enable byte, `rdata`, `err` and `pending` are zero.
- R9: A read or write at an address of 8 or above changes no register. On the next cycle `err` is 1, and for a read `rdata` is 0. `err` is 0 on the cycle after any cycle without an illegal access.
- R10: `rdata` is updated one cycle after a read strobe. It holds its value on cycles that follow no read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | DW | Event lines ORed into status byte 0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address; one bit wider than needed so that out-of-range addresses can be expressed |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| err | output | 1 | One-cycle flag for an out-of-range access |
| pending | output | 1 | Interrupt request from byte 0 |

## Verification
A corrupted status or enable byte 0 shows up on `pending` on the clock edge where it happens, whenever the affected bit is enabled. It also shows up on `rdata` one cycle after any read of that byte. A wrong decode of the address halves, or a missed out-of-range guard, shows up one cycle later as a wrong `rdata` or `err`. A clobbered byte shows up on the next read-back of it. Because the bench model is compared on every cycle, each of these errors is caught within one cycle of the access that exposes it.

// File: rtl/gpe_bank.sv
module gpe_bank #(
  parameter int BANK_LEN = 8,
  parameter int DW       = 8,
  localparam int HALF    = BANK_LEN / 2,
  localparam int IW      = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int AW      = $clog2(BANK_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          pending
);

  logic [HALF-1:0][DW-1:0] st_q;
  logic [HALF-1:0][DW-1:0] en_q;
  logic [DW-1:0] st0, en0;
  logic          in_range, is_st, st_wr, en_wr;
  logic [AW-1:0] en_idx;
  logic [IW-1:0] st_sel, en_sel;

  assign in_range = addr < AW'(BANK_LEN);
  assign is_st    = addr < AW'(HALF);
  assign en_idx   = addr - AW'(HALF);
  assign st_sel   = addr[IW-1:0];
  assign en_sel   = en_idx[IW-1:0];
  assign st_wr    = wr_en && in_range && is_st;
  assign en_wr    = wr_en && in_range && !is_st;

  assign st0     = st_q[0];
  assign en0     = en_q[0];
  assign pending = |(st0 & en0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      for (int i = 0; i < HALF; i++) begin
        st_q[i] <= (st_q[i] & ~((st_wr && addr == AW'(i)) ? wdata : '0))
                   | ((i == 0) ? evt_in : '0);
        if (en_wr && en_idx == AW'(i)) en_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= (wr_en || rd_en) && !in_range;
      if (rd_en) rdata <= !in_range ? '0 : (is_st ? st_q[st_sel] : en_q[en_sel]);
    end
  end

endmodule

// File: rtl/gpe_bank_chk.sv
module gpe_bank_chk #(
  parameter int BANK_LEN = 8,
  parameter int DW       = 8,
  parameter int AW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] evt_in,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          err,
  input logic          pending,
  input logic [DW-1:0] st0,
  input logic [DW-1:0] en0
);

  p_err_on_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr >= AW'(BANK_LEN)) |=> err);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en || rd_en) && addr >= AW'(BANK_LEN)) |=> !err);

  p_illegal_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= AW'(BANK_LEN)) |=> rdata == '0);

  p_event_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((st0 & $past(evt_in)) == $past(evt_in)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && evt_in == '0) |=> st0 == ($past(st0) & ~$past(wdata)));

  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(BANK_LEN / 2)) |=> $stable(en0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_no_pending_unenabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 == '0) |-> !pending);

endmodule

bind gpe_bank gpe_bank_chk #(.BANK_LEN(BANK_LEN), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .pending(pending),
  .st0(st0), .en0(en0)
);

// File: tb/gpe_bank_test.sv
module gpe_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN  = 8;
  localparam int HALFN = LEN / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       err;
  logic       pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_st [HALFN];
  int m_en [HALFN];
  int m_rdata = 0;
  int m_err = 0;

  gpe_bank #(.BANK_LEN(LEN), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .pending(pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < HALFN; i++) begin m_st[i] = 0; m_en[i] = 0; end
    m_rdata = 0; m_err = 0;
  endtask

  task automatic compare(string req);
    int exp_p;
    exp_p = ((m_st[0] & m_en[0]) != 0) ? 1 : 0;
    check(req, "rdata", int'(rdata), m_rdata);
    check(req, "err", int'(err), m_err);
    check(req, "pending", int'(pending), exp_p);
  endtask

  task automatic cyc(string req, bit w, bit r, int a, int d, int ev);
    int a_ok, clr;
    wr_en = w; rd_en = r; addr = 4'(a); wdata = 8'(d); evt_in = 8'(ev);
    @(posedge clk);
    a_ok = (a < LEN) ? 1 : 0;
    m_err = ((w || r) && !a_ok) ? 1 : 0;
    if (r) m_rdata = !a_ok ? 0 : (a < HALFN ? m_st[a] : m_en[a - HALFN]);
    for (int i = 0; i < HALFN; i++) begin
      clr = (w && a == i) ? d : 0;
      m_st[i] = (m_st[i] & ~clr & 255) | ((i == 0) ? ev : 0);
    end
    if (w && a_ok && a >= HALFN) m_en[a - HALFN] = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt_in = '0;
    compare(req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    #1;
    compare("R8");
    @(negedge clk);
    compare("R8");
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    apply_reset();
    // R2 R4: program enables and read them back
    cyc("R4", 1, 0, 4, 'h0F, 0);
    cyc("R2", 0, 1, 4, 0, 0);
    cyc("R4", 1, 0, 5, 'hAA, 0);
    cyc("R2", 0, 1, 5, 0, 0);
    // R5 R7: events set byte 0 and raise pending
    cyc("R5", 0, 0, 0, 0, 'h03);
    cyc("R1", 0, 1, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0);
    // R3: write-one-to-clear
    cyc("R3", 1, 0, 0, 'h01, 0);
    cyc("R1", 0, 1, 0, 0, 0);
    // R6: event wins over clear
    cyc("R6", 1, 0, 0, 'h02, 'h02);
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R3", 1, 0, 0, 'h02, 0);
    // R7: unenabled bit and other bytes do not raise pending
    cyc("R7", 0, 0, 0, 0, 'h80);
    cyc("R7", 1, 0, 5, 'hFF, 0);
    cyc("R7", 1, 0, 1, 'hFF, 0);
    cyc("R1", 0, 1, 1, 0, 0);
    // R10: read during write returns the old value
    cyc("R10", 1, 1, 4, 'hF0, 0);
    cyc("R4", 0, 1, 4, 0, 0);
    // R9: illegal accesses
    cyc("R9", 1, 0, 8, 'hFF, 0);
    cyc("R9", 0, 1, 12, 0, 0);
    cyc("R9", 1, 1, 15, 'h00, 0);
    cyc("R9", 0, 0, 0, 0, 0);
    cyc("R9", 0, 1, 4, 0, 0);
    cyc("R9", 0, 1, 0, 0, 0);
    // R10: hold over idle cycles
    cyc("R10", 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 3, 0, 0);
    // R5: several events accumulate
    cyc("R5", 0, 0, 0, 0, 'h10);
    cyc("R5", 0, 0, 0, 0, 'h20);
    cyc("R5", 0, 1, 0, 0, 0);
    // R8: reset mid-run clears everything
    apply_reset();
    cyc("R8", 0, 1, 4, 0, 0);
    cyc("R8", 0, 1, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule